// File: doc/BRIEF.md
# Sample Strobe Generator with Selectable Source and Divider

This block produces the strobe that tells change-of-state logic when to look at its inputs. It takes two slow clock-like signals as ordinary data inputs: an on-board reference (nominally 50 MHz) and an external clock that must be free-running. Each of them goes through its own synchronizer and rising-edge detector. The result is one single-cycle tick per source edge, in the system clock domain.

A control word picks the source first. Then it picks whether the chosen tick stream passes straight through or is divided by a 12-bit divisor. The output is a registered, single-cycle enable pulse. Rewriting the control word restarts the divider, so a new rate takes effect at once. No analog clock muxing takes place: the source switch is a data select on tick streams that are already synchronized.

Top module: `sample_clk_gen`

## Requirements
- R1: Synchronous active-high reset drives `strobe_o` low and selects the reference source, undivided, with divisor 0. It also clears all synchronizer and counter state.
- R2: The selected source is sampled on each clock edge. A rising transition first seen high at clock edge k gives `strobe_o` high for exactly one cycle, in the cycle that follows edge k+2. Each source rising edge gives at most one strobe.
- R3: Control bit 12 selects the source: 0 selects `ref_clk_i` and 1 selects `ext_clk_i`. The edges of the other input have no effect on `strobe_o`.
- R4: Control bit 13 selects the output form. With 1, the output is the divided stream. With 0, every tick of the selected source appears on the output.
- R5: Control bits 11:0 hold the divisor D. In divided mode, one strobe is produced per D+1 source ticks. After a restart, the first strobe comes from tick number D+1.
- R6: A divisor of 0 in divided mode passes every source tick to the output.
- R7: A control write takes effect on the edge that samples it, and it clears the divide counter to zero. If a source tick falls in the cycle of the write, the strobe for that tick is judged with the settings and count that were in place before the write.
- R8: Changing the source select never creates a strobe by itself, even when the newly chosen input is already high. Both synchronizers run all the time.
- R9: The largest divisor, 4095, gives exactly one strobe per 4096 source ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | On-board reference clock, taken as asynchronous data |
| ext_clk_i | input | 1 | External free-running clock, taken as asynchronous data |
| ctl_wr_i | input | 1 | Control write strobe, one cycle |
| ctl_wdata_i | input | 14 | Control word: [13] divided/undivided, [12] source, [11:0] divisor |
| strobe_o | output | 1 | Single-cycle sample enable |

## Verification
A control write and a source tick can land in the same clock cycle. That cycle must produce a strobe decided by the old settings and old count, and the count must still be cleared. The bench provokes this case by watching its own model. It waits for a cycle in which the model predicts a tick, and it places the write in exactly that cycle. It does this with several divisors and in both output forms. A behavioural model in the bench predicts `strobe_o` for every clock, and the bench compares the model against the design on every cycle, so any misordering between the restart and the tick shows up as a mismatch in that cycle or later in the divided sequence.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int DIV_W    = 12;
  localparam int NUM_SRC  = 2;
  localparam int SRC_BIT  = DIV_W;
  localparam int POST_BIT = DIV_W + 1;
  localparam int CTL_W    = DIV_W + 2;

  typedef struct packed {
    logic             post;
    logic             src;
    logic [DIV_W-1:0] div;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{post: 1'b0, src: 1'b0, div: '0};
endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] shift_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) shift_q <= '0;
    else       shift_q <= {shift_q[STAGES-1:0], async_i};
  end

  assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/sclk_ctl_reg.sv
module sclk_ctl_reg
  import sclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctl_o <= CTL_RESET;
    end else if (wr_i) begin
      ctl_o.post <= wdata_i[POST_BIT];
      ctl_o.src  <= wdata_i[SRC_BIT];
      ctl_o.div  <= wdata_i[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/sclk_tick_div.sv
module sclk_tick_div #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         hit_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end = (cnt_q == div_i);
  assign hit_o  = tick_i & at_end;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) cnt_q <= '0;
    else if (tick_i)        cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sample_clk_gen.sv
module sample_clk_gen
  import sclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ref_clk_i,
  input  logic             ext_clk_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic             strobe_o
);
  ctl_t               ctl_q;
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_rise;
  logic               sel_tick;
  logic               div_hit;
  logic [DIV_W-1:0]   div_cnt;

  assign src_raw = {ext_clk_i, ref_clk_i};

  sclk_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl_q)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i (src_raw[g]),
      .rise_o  (src_rise[g])
    );
  end

  assign sel_tick = src_rise[ctl_q.src];

  sclk_tick_div #(.W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (ctl_wr_i),
    .tick_i    (sel_tick),
    .div_i     (ctl_q.div),
    .hit_o     (div_hit),
    .cnt_o     (div_cnt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) strobe_o <= 1'b0;
    else       strobe_o <= ctl_q.post ? div_hit : sel_tick;
  end
endmodule

// File: rtl/sample_clk_gen_chk.sv
module sample_clk_gen_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         wr,
  input logic         tick,
  input logic         post,
  input logic [W-1:0] div,
  input logic [W-1:0] cnt,
  input logic         strobe
);
  AST_STROBE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(tick)); // R2
  AST_UNDIV_PASS: assert property (@(posedge clk) disable iff (rst)
    (!post && tick) |=> strobe); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= div); // R5
  AST_DIV_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (post && div == '0 && tick) |=> strobe); // R6
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt == '0)); // R7
endmodule

bind sample_clk_gen sample_clk_gen_chk #(.W(sclk_pkg::DIV_W)) u_chk (
  .clk    (clk_i),
  .rst    (rst_i),
  .wr     (ctl_wr_i),
  .tick   (sel_tick),
  .post   (ctl_q.post),
  .div    (ctl_q.div),
  .cnt    (div_cnt),
  .strobe (strobe_o)
);

// File: tb/sim_sample_clk_gen.sv
module sim_sample_clk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_clk = 1'b0;
  logic        ext_clk = 1'b0;
  logic        wr = 1'b0;
  logic [13:0] wdata = '0;
  logic        strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // source generators (half periods in clock cycles)
  int ref_half = 3, ext_half = 5, ref_ph = 0, ext_ph = 0;

  // behavioural model
  int  m_cnt = 0, m_div = 0;
  bit  m_post = 0, m_src = 0, m_tick = 0, m_exp = 0;
  bit  r0 = 0, r1 = 0, r2 = 0, e0 = 0, e1 = 0, e2 = 0;

  always #2 clk = ~clk;

  sample_clk_gen u0 (
    .clk_i(clk), .rst_i(rst), .ref_clk_i(ref_clk), .ext_clk_i(ext_clk),
    .ctl_wr_i(wr), .ctl_wdata_i(wdata), .strobe_o(strobe)
  );

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s strobe actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // model of the edge just taken, using the inputs that were present at it
  task automatic model_edge();
    if (rst) begin
      m_cnt = 0; m_div = 0; m_post = 0; m_src = 0; m_exp = 0;
      r0 = 0; r1 = 0; r2 = 0; e0 = 0; e1 = 0; e2 = 0;
    end else begin
      m_exp = m_tick && (!m_post || m_cnt == m_div);
      if (wr) begin
        m_cnt = 0;
        m_post = wdata[13]; m_src = wdata[12]; m_div = int'(wdata[11:0]);
      end else if (m_tick) begin
        m_cnt = (m_cnt == m_div) ? 0 : m_cnt + 1;
      end
      r2 = r1; r1 = r0; r0 = ref_clk;
      e2 = e1; e1 = e0; e0 = ext_clk;
    end
    m_tick = m_src ? (e1 && !e2) : (r1 && !r2);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_edge();
      check(cur_req, strobe, m_exp);
      ref_ph++; if (ref_ph >= ref_half) begin ref_ph = 0; ref_clk = ~ref_clk; end
      ext_ph++; if (ext_ph >= ext_half) begin ext_ph = 0; ext_clk = ~ext_clk; end
    end
  endtask

  task automatic write_ctl(input bit post, input bit src, input int div);
    wr = 1'b1; wdata = {post, src, 12'(div)};
    cyc(1);
    wr = 1'b0;
  endtask

  task automatic wait_tick();
    while (!m_tick) cyc(1);
  endtask

  initial begin
    cur_req = "R1"; cyc(4);
    rst = 1'b0;
    check("R1", strobe, 1'b0);
    cyc(60);                                   // reset default: ref, undivided
    cur_req = "R2"; ref_half = 4; cyc(80);     // basic latency, one strobe per edge
    cur_req = "R4"; write_ctl(1, 0, 3); cyc(200);
    cur_req = "R5"; write_ctl(1, 0, 5); cyc(300);
    cur_req = "R3"; write_ctl(0, 1, 0); cyc(150);
    write_ctl(1, 1, 2); cyc(200);
    cur_req = "R6"; write_ctl(1, 1, 0); cyc(150);
    write_ctl(1, 0, 0); cyc(100);
    cur_req = "R8";
    for (int k = 0; k < 12; k++) begin
      cyc(k % 7);
      write_ctl(0, k[0], 0);
    end
    cyc(60);
    cur_req = "R7";
    for (int k = 0; k < 8; k++) begin
      wait_tick();
      write_ctl(k[1], k[2], k % 3 + 1);
      cyc(25 + k);
    end
    write_ctl(1, 0, 2); cyc(30);
    wait_tick(); write_ctl(1, 0, 2); cyc(40);
    cur_req = "R9"; ref_half = 1; write_ctl(1, 0, 4095); cyc(8192 * 2 + 100);
    cur_req = "R1"; ref_half = 2; write_ctl(1, 1, 7); cyc(37);
    rst = 1'b1; cyc(3); check("R1", strobe, 1'b0);
    rst = 1'b0; cyc(80);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule